// File: doc/BRIEF.md
# DAC Sample FIFO Controller

This block sits between a register-style write port and a digital-to-analog converter. It holds output samples, picks which one the converter shows, and reports buffer state as status flags. Those flags are routed either to an interrupt line or to a DMA request line. The converter itself is outside the block. Only the output code is produced here.

There are three working modes. In bypass mode, a write goes straight into the output code. In FIFO mode, writes are queued and each trigger steps the read pointer forward. In swing mode, the buffer is filled once and each trigger then sweeps the read pointer back and forth between the full and the one-entry-left states. This repeats a waveform without any further writes.

The trigger comes either from a hardware pin or from a one-shot software bit. Both pointers are visible at the ports. The buffer depth is set by a parameter and is reported as a 3-bit size code.

Top module: `dac_sample_fifo`

## Requirements
- R1: With mode code 0 (bypass) and the enable set, a write puts `wdata_i` on `dac_code_o` after the next clock edge. Neither pointer moves.
- R2: With mode code 1 (FIFO), a write while the buffer holds fewer than DEPTH entries stores the word at `wr_ptr_o`. The write pointer then advances by one, modulo DEPTH, and the output code is unchanged.
- R3: In mode 1, a trigger while two or more entries remain advances `rd_ptr_o` by one. The entry at the new read pointer becomes `dac_code_o` on the same edge.
- R4: With mode code 2 (swing) and a full buffer, each trigger raises the read pointer until one entry remains. Later triggers lower it until the buffer is full again, and the sweep repeats. The output follows the entry at the read pointer, and the underflow flag is never set.
- R5: A write in mode 1 or 2 while DEPTH entries are held is dropped: the write pointer and the contents stay as they are. The write sets `ovf_o`.
- R6: In mode 1, a trigger while one or zero entries remain sets `udf_o`. The read pointer and the output code do not change.
- R7: `ovf_o` and `udf_o` stay set until a pulse on `clr_ovf_i` or `clr_udf_i` clears them. If a set and a clear arrive in the same cycle, the flag ends up set.
- R8: `full_o` is high when DEPTH entries are held. `near_empty_o` is high when exactly one entry is held. `wmark_o` is high when the held count is below `wmark_i`, which may be set up to DEPTH.
- R9: `ie_i` selects which conditions request service: bit 0 for overflow or underflow, bit 1 for watermark, bit 2 for nearly empty, bit 3 for full. When any selected condition is present, `dma_req_o` is asserted if `dma_en_i` is high and `irq_o` is asserted otherwise. The other output stays low.
- R10: With `enable_i` low, or with the reserved mode code 3, writes and triggers have no effect. A `fifo_rst_i` pulse sets both pointers to 0 and empties the buffer, but only while `enable_i` is low.
- R11: A `sw_rst_i` pulse returns both pointers, the held count, the sticky flags and the output code to 0.
- R12: With `trig_sel_i` = 0 the `hw_trig_i` pin is the trigger. With `trig_sel_i` = 1 only a `sw_trig_i` pulse triggers, and it acts one clock edge later than a hardware trigger would.
- R13: `depth_code_o` reports the parameter DEPTH_CODE, where DEPTH = 2^(DEPTH_CODE+1) and DEPTH_CODE ranges from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enable_i | input | 1 | Converter enable; writes and triggers act only while high |
| mode_i | input | 2 | 0 bypass, 1 FIFO, 2 swing, 3 reserved |
| trig_sel_i | input | 1 | 0 hardware trigger, 1 software trigger |
| hw_trig_i | input | 1 | Hardware trigger pulse |
| sw_trig_i | input | 1 | Software trigger pulse (one-shot) |
| wr_i | input | 1 | Data write strobe |
| wdata_i | input | DATA_W | Data word to write |
| fifo_rst_i | input | 1 | Pointer reset pulse |
| sw_rst_i | input | 1 | Block state reset pulse |
| clr_ovf_i | input | 1 | Write-one-to-clear for the overflow flag |
| clr_udf_i | input | 1 | Write-one-to-clear for the underflow flag |
| wmark_i | input | DEPTH_CODE+2 | Watermark level, from 0 to DEPTH |
| ie_i | input | 4 | Service request enables |
| dma_en_i | input | 1 | Route requests to DMA instead of the interrupt |
| dac_code_o | output | DATA_W | Code presented to the converter |
| rd_ptr_o | output | DEPTH_CODE+1 | Read pointer |
| wr_ptr_o | output | DEPTH_CODE+1 | Write pointer |
| full_o | output | 1 | Buffer holds DEPTH entries |
| near_empty_o | output | 1 | Buffer holds exactly one entry |
| wmark_o | output | 1 | Held count is below the watermark |
| ovf_o | output | 1 | Sticky overflow flag |
| udf_o | output | 1 | Sticky underflow flag |
| irq_o | output | 1 | Interrupt request |
| dma_req_o | output | 1 | DMA request |
| depth_code_o | output | 3 | Depth size code |

## Verification
The bench targets the turning points of the swing sweep. A design that reverses one step late or one step early would wrap the read pointer past the written data, or would stop short of the full state. The bench writes into a full buffer: a controller that wraps its pointers would overwrite the oldest sample and clear `full_o` instead of raising overflow. It also triggers at one remaining entry, where a design that moves anyway would show stale data with no underflow. The remaining targets are:
- a clear and an overflow arriving in the same cycle, where a design that lets the clear win loses the event;
- a pointer reset issued while the block is enabled, which a design must ignore;
- the one-cycle lag of the software trigger, which a design without the one-shot register would not show.

// File: rtl/dsf_pkg.sv
package dsf_pkg;
   typedef enum logic [1:0] {
      MODE_BYPASS = 2'd0,
      MODE_FIFO   = 2'd1,
      MODE_SWING  = 2'd2,
      MODE_RSVD   = 2'd3
   } dsf_mode_e;

   // bit positions of the service-request enable vector
   localparam int unsigned IE_UV   = 0;
   localparam int unsigned IE_WM   = 1;
   localparam int unsigned IE_NE   = 2;
   localparam int unsigned IE_FULL = 3;
   localparam int unsigned IE_W    = 4;
endpackage

// File: rtl/dsf_ptr_ctrl.sv
module dsf_ptr_ctrl
   import dsf_pkg::*;
#(
   parameter int unsigned DEPTH_CODE = 3
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  enable_i,
   input  dsf_mode_e             mode_i,
   input  logic                  wr_i,
   input  logic                  trig_i,
   input  logic                  fifo_rst_i,
   input  logic                  sw_rst_i,
   output logic [DEPTH_CODE:0]   wr_ptr_o,
   output logic [DEPTH_CODE:0]   rd_ptr_o,
   output logic [DEPTH_CODE+1:0] count_o,
   output logic                  store_o,
   output logic                  move_o,
   output logic [DEPTH_CODE:0]   next_rd_o,
   output logic                  bypass_ld_o,
   output logic                  ovf_set_o,
   output logic                  udf_set_o
);
   localparam int unsigned PTR_W = DEPTH_CODE + 1;
   localparam int unsigned CNT_W = DEPTH_CODE + 2;
   localparam int unsigned DEPTH = 2 ** PTR_W;
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ONE_C   = CNT_W'(1);

   logic [PTR_W-1:0] wr_q, rd_q;
   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic             up_q;
   logic             live, in_fifo, in_swing, is_full;
   logic             fifo_mv, swing_act, go_up, mv_up, mv_dn, clr_ptrs;

   assign live      = enable_i && (mode_i != MODE_RSVD);
   assign in_fifo   = live && (mode_i == MODE_FIFO);
   assign in_swing  = live && (mode_i == MODE_SWING);
   assign is_full   = (cnt_q == DEPTH_C);

   assign fifo_mv   = in_fifo && trig_i && (cnt_q > ONE_C);
   assign udf_set_o = in_fifo && trig_i && (cnt_q <= ONE_C);
   assign swing_act = in_swing && trig_i && (cnt_q != '0);
   // the sweep turns around at one entry left and at full
   assign go_up     = up_q ? (cnt_q > ONE_C) : (cnt_q == DEPTH_C);
   assign mv_up     = fifo_mv || (swing_act && go_up);
   assign mv_dn     = swing_act && !go_up;

   assign store_o     = (in_fifo || (in_swing && !swing_act)) && wr_i && !is_full;
   assign ovf_set_o   = (in_fifo || in_swing) && wr_i && is_full;
   assign bypass_ld_o = live && (mode_i == MODE_BYPASS) && wr_i;
   assign move_o      = mv_up || mv_dn;
   assign next_rd_o   = mv_up ? rd_q + PTR_W'(1) : (mv_dn ? rd_q - PTR_W'(1) : rd_q);
   assign cnt_nx      = cnt_q + CNT_W'(store_o) - CNT_W'(mv_up) + CNT_W'(mv_dn);
   assign clr_ptrs    = sw_rst_i || (fifo_rst_i && !enable_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else if (clr_ptrs) begin
         wr_q  <= '0;
         rd_q  <= '0;
         cnt_q <= '0;
         up_q  <= 1'b1;
      end else begin
         if (store_o) wr_q <= wr_q + PTR_W'(1);
         rd_q  <= next_rd_o;
         cnt_q <= cnt_nx;
         if (swing_act) begin
            if (cnt_nx == DEPTH_C)    up_q <= 1'b1;
            else if (cnt_nx == ONE_C) up_q <= 1'b0;
         end
      end
   end

   assign wr_ptr_o = wr_q;
   assign rd_ptr_o = rd_q;
   assign count_o  = cnt_q;

   a_r8_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_q <= DEPTH_C);
   a_r2_ptr_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_q - rd_q) == cnt_q[PTR_W-1:0]);
   a_r10_frozen_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!enable_i && !fifo_rst_i && !sw_rst_i) |=> ($stable(wr_q) && $stable(rd_q)));
   a_r5_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_full && !move_o && !clr_ptrs) |=> $stable(wr_q));
endmodule

// File: rtl/dsf_store.sv
module dsf_store #(
   parameter int unsigned DATA_W     = 12,
   parameter int unsigned DEPTH_CODE = 3
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                store_i,
   input  logic [DEPTH_CODE:0] wr_ptr_i,
   input  logic [DATA_W-1:0]   wdata_i,
   input  logic                move_i,
   input  logic [DEPTH_CODE:0] next_rd_i,
   input  logic                bypass_ld_i,
   input  logic                sw_rst_i,
   output logic [DATA_W-1:0]   code_o
);
   localparam int unsigned PTR_W = DEPTH_CODE + 1;
   localparam int unsigned DEPTH = 2 ** PTR_W;

   logic [DATA_W-1:0] ent [DEPTH];
   logic [DATA_W-1:0] code_q;

   for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i) begin
         if (store_i && (wr_ptr_i == PTR_W'(i))) q <= wdata_i;
      end
      assign ent[i] = q;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          code_q <= '0;
      else if (sw_rst_i)    code_q <= '0;
      else if (bypass_ld_i) code_q <= wdata_i;
      else if (move_i)      code_q <= ent[next_rd_i];
   end

   assign code_o = code_q;

   a_r1_bypass_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bypass_ld_i && !sw_rst_i) |=> (code_o == $past(wdata_i)));
   a_r6_code_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!bypass_ld_i && !move_i && !sw_rst_i) |=> $stable(code_o));
endmodule

// File: rtl/dsf_flags.sv
module dsf_flags
   import dsf_pkg::*;
#(
   parameter int unsigned DEPTH_CODE = 3
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [DEPTH_CODE+1:0] count_i,
   input  logic [DEPTH_CODE+1:0] wmark_i,
   input  logic                  ovf_set_i,
   input  logic                  udf_set_i,
   input  logic                  clr_ovf_i,
   input  logic                  clr_udf_i,
   input  logic                  sw_rst_i,
   input  logic [IE_W-1:0]       ie_i,
   input  logic                  dma_en_i,
   output logic                  full_o,
   output logic                  near_empty_o,
   output logic                  wmark_o,
   output logic                  ovf_o,
   output logic                  udf_o,
   output logic                  irq_o,
   output logic                  dma_req_o
);
   localparam int unsigned CNT_W = DEPTH_CODE + 2;
   localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(2 ** (DEPTH_CODE + 1));

   logic ovf_q, udf_q, want;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ovf_q <= 1'b0;
         udf_q <= 1'b0;
      end else if (sw_rst_i) begin
         ovf_q <= 1'b0;
         udf_q <= 1'b0;
      end else begin
         ovf_q <= ovf_set_i || (ovf_q && !clr_ovf_i);
         udf_q <= udf_set_i || (udf_q && !clr_udf_i);
      end
   end

   assign full_o       = (count_i == DEPTH_C);
   assign near_empty_o = (count_i == CNT_W'(1));
   assign wmark_o      = (count_i < wmark_i);
   assign ovf_o        = ovf_q;
   assign udf_o        = udf_q;

   assign want = (ie_i[IE_UV] && (ovf_q || udf_q)) || (ie_i[IE_WM] && wmark_o)
              || (ie_i[IE_NE] && near_empty_o) || (ie_i[IE_FULL] && full_o);
   assign irq_o     = want && !dma_en_i;
   assign dma_req_o = want && dma_en_i;

   a_r7_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ovf_q && !clr_ovf_i && !sw_rst_i) |=> ovf_q);
   a_r7_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (udf_set_i && !sw_rst_i) |=> udf_q);
   a_r9_one_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({irq_o, dma_req_o, ~(|ie_i) & (irq_o | dma_req_o)}));
endmodule

// File: rtl/dac_sample_fifo.sv
module dac_sample_fifo
   import dsf_pkg::*;
#(
   parameter int unsigned DATA_W     = 12,
   parameter int unsigned DEPTH_CODE = 3
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic                  enable_i,
   input  logic [1:0]            mode_i,
   input  logic                  trig_sel_i,
   input  logic                  hw_trig_i,
   input  logic                  sw_trig_i,
   input  logic                  wr_i,
   input  logic [DATA_W-1:0]     wdata_i,
   input  logic                  fifo_rst_i,
   input  logic                  sw_rst_i,
   input  logic                  clr_ovf_i,
   input  logic                  clr_udf_i,
   input  logic [DEPTH_CODE+1:0] wmark_i,
   input  logic [3:0]            ie_i,
   input  logic                  dma_en_i,
   output logic [DATA_W-1:0]     dac_code_o,
   output logic [DEPTH_CODE:0]   rd_ptr_o,
   output logic [DEPTH_CODE:0]   wr_ptr_o,
   output logic                  full_o,
   output logic                  near_empty_o,
   output logic                  wmark_o,
   output logic                  ovf_o,
   output logic                  udf_o,
   output logic                  irq_o,
   output logic                  dma_req_o,
   output logic [2:0]            depth_code_o
);
   localparam int unsigned PTR_W = DEPTH_CODE + 1;
   localparam int unsigned CNT_W = DEPTH_CODE + 2;

   if (DEPTH_CODE > 7) begin : g_bad_depth
      $error("DEPTH_CODE must lie in 0..7");
   end
   if (DATA_W < 1 || DATA_W > 32) begin : g_bad_width
      $error("DATA_W must lie in 1..32");
   end

   logic             swtrig_q, trig;
   logic [CNT_W-1:0] count;
   logic [PTR_W-1:0] next_rd;
   logic             store, move, bypass_ld, ovf_set, udf_set;

   // software trigger bit clears itself one cycle after it is set
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       swtrig_q <= 1'b0;
      else if (sw_rst_i) swtrig_q <= 1'b0;
      else               swtrig_q <= sw_trig_i;
   end
   assign trig = trig_sel_i ? swtrig_q : hw_trig_i;

   dsf_ptr_ctrl #(.DEPTH_CODE(DEPTH_CODE)) u_ptr (
      .clk_i, .rst_ni, .enable_i,
      .mode_i      (dsf_mode_e'(mode_i)),
      .wr_i,
      .trig_i      (trig),
      .fifo_rst_i, .sw_rst_i,
      .wr_ptr_o, .rd_ptr_o,
      .count_o     (count),
      .store_o     (store),
      .move_o      (move),
      .next_rd_o   (next_rd),
      .bypass_ld_o (bypass_ld),
      .ovf_set_o   (ovf_set),
      .udf_set_o   (udf_set)
   );

   dsf_store #(.DATA_W(DATA_W), .DEPTH_CODE(DEPTH_CODE)) u_store (
      .clk_i, .rst_ni,
      .store_i     (store),
      .wr_ptr_i    (wr_ptr_o),
      .wdata_i,
      .move_i      (move),
      .next_rd_i   (next_rd),
      .bypass_ld_i (bypass_ld),
      .sw_rst_i,
      .code_o      (dac_code_o)
   );

   dsf_flags #(.DEPTH_CODE(DEPTH_CODE)) u_flags (
      .clk_i, .rst_ni,
      .count_i     (count),
      .wmark_i,
      .ovf_set_i   (ovf_set),
      .udf_set_i   (udf_set),
      .clr_ovf_i, .clr_udf_i, .sw_rst_i, .ie_i, .dma_en_i,
      .full_o, .near_empty_o, .wmark_o, .ovf_o, .udf_o, .irq_o, .dma_req_o
   );

   assign depth_code_o = 3'(DEPTH_CODE);

   a_r12_sw_trig_one_shot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (swtrig_q && !sw_trig_i) |=> !swtrig_q);
endmodule

// File: tb/dac_sample_fifo_tb_top.sv
`timescale 1ns/1ps
module dac_sample_fifo_tb_top;
   localparam int DW = 12;
   localparam int DC = 1; // depth 4

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 0, trig_sel = 0, hw_trig = 0, sw_trig = 0, wr = 0;
   logic fifo_rst = 0, sw_rst = 0, clr_ovf = 0, clr_udf = 0, dma_en = 0;
   logic [1:0] mode = 0;
   logic [DW-1:0] wdata = 0;
   logic [DC+1:0] wmark = 0;
   logic [3:0] ie = 0;
   logic [DW-1:0] code;
   logic [DC:0] rd_ptr, wr_ptr;
   logic full, ne, wm, ovf, udf, irq, dma;
   logic [2:0] dcode;

   int checks = 0, errors = 0;
   bit done = 0;
   int exp_q[$];
   logic [DW-1:0] prev_code = '0;

   always #4 clk = ~clk;

   dac_sample_fifo #(.DATA_W(DW), .DEPTH_CODE(DC)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .enable_i(enable), .mode_i(mode),
      .trig_sel_i(trig_sel), .hw_trig_i(hw_trig), .sw_trig_i(sw_trig),
      .wr_i(wr), .wdata_i(wdata), .fifo_rst_i(fifo_rst), .sw_rst_i(sw_rst),
      .clr_ovf_i(clr_ovf), .clr_udf_i(clr_udf), .wmark_i(wmark), .ie_i(ie),
      .dma_en_i(dma_en), .dac_code_o(code), .rd_ptr_o(rd_ptr), .wr_ptr_o(wr_ptr),
      .full_o(full), .near_empty_o(ne), .wmark_o(wm), .ovf_o(ovf), .udf_o(udf),
      .irq_o(irq), .dma_req_o(dma), .depth_code_o(dcode)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // driver side of the scoreboard: expected next converter code
   task automatic expect_code(input int v);
      exp_q.push_back(v);
   endtask

   // monitor: every change of the output code is matched to the queue
   always @(negedge clk) begin
      if (rst_n && code !== prev_code) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R1/R3/R4 unexpected code actual=%0h expected=%0h", code, prev_code);
         end else begin
            int e;
            e = exp_q.pop_front();
            if (int'(code) != e) begin
               errors++;
               $display("FAIL R1/R3/R4 code actual=%0h expected=%0h", code, e);
            end
         end
         prev_code = code;
      end
   end

   task automatic do_wr(input logic [DW-1:0] d);
      wr = 1; wdata = d;
      @(negedge clk);
      wr = 0;
   endtask

   task automatic do_hw;
      hw_trig = 1;
      @(negedge clk);
      hw_trig = 0;
   endtask

   task automatic summary;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // reset state
      chk("R11 reset code", code, 0);
      chk("R11 reset rd", rd_ptr, 0);
      chk("R11 reset wr", wr_ptr, 0);
      chk("R8 reset full", full, 0);
      chk("R9 reset irq", irq, 0);
      chk("R13 depth code", dcode, DC);

      // R1 bypass
      enable = 1; mode = 0; wmark = 4;
      expect_code('h123);
      do_wr('h123);
      chk("R1 wr ptr still", wr_ptr, 0);
      chk("R1 rd ptr still", rd_ptr, 0);

      // R2 fifo writes
      mode = 1;
      for (int i = 0; i < 4; i++) begin
         do_wr(DW'('h10 + i));
         chk("R2 wr ptr", wr_ptr, (i + 1) % 4);
      end
      chk("R2 code unchanged", code, 'h123);
      chk("R8 full", full, 1);
      chk("R8 wmark at full", wm, 0);
      do_wr('h14);
      chk("R5 ovf", ovf, 1);
      chk("R5 wr ptr kept", wr_ptr, 0);

      // R9 routing
      ie = 4'b0001;
      @(negedge clk);
      chk("R9 irq", irq, 1);
      chk("R9 dma low", dma, 0);
      dma_en = 1;
      @(negedge clk);
      chk("R9 irq masked by dma", irq, 0);
      chk("R9 dma", dma, 1);
      dma_en = 0; ie = 4'b1000;
      @(negedge clk);
      chk("R9 full irq", irq, 1);
      ie = 0;

      // R7 clear and set-wins
      clr_ovf = 1; @(negedge clk); clr_ovf = 0;
      chk("R7 ovf cleared", ovf, 0);
      clr_ovf = 1; wr = 1; wdata = 'h15;
      @(negedge clk);
      clr_ovf = 0; wr = 0;
      chk("R7 set wins", ovf, 1);
      @(negedge clk);
      chk("R7 ovf held", ovf, 1);
      clr_ovf = 1; @(negedge clk); clr_ovf = 0;

      // R3 triggers
      expect_code('h11); do_hw();
      chk("R3 rd", rd_ptr, 1);
      chk("R8 wmark below", wm, 1);
      expect_code('h12); do_hw();
      expect_code('h13); do_hw();
      chk("R3 rd 3", rd_ptr, 3);
      chk("R8 near empty", ne, 1);
      do_hw();
      chk("R6 udf", udf, 1);
      chk("R6 rd kept", rd_ptr, 3);

      // R12 trigger select
      clr_udf = 1; @(negedge clk); clr_udf = 0;
      trig_sel = 1;
      do_hw();
      chk("R12 hw ignored", udf, 0);
      sw_trig = 1; @(negedge clk); sw_trig = 0;
      chk("R12 sw not yet", udf, 0);
      @(negedge clk);
      chk("R12 sw acted", udf, 1);
      trig_sel = 0;

      // R10 enable gating and pointer reset
      fifo_rst = 1; @(negedge clk); fifo_rst = 0;
      chk("R10 fifo rst ignored enabled", rd_ptr, 3);
      enable = 0;
      do_wr('h55);
      chk("R10 write ignored off", ne, 1);
      fifo_rst = 1; @(negedge clk); fifo_rst = 0;
      chk("R10 rd reset", rd_ptr, 0);
      chk("R10 emptied", ne, 0);
      enable = 1; mode = 3;
      do_wr('h56);
      chk("R10 mode 3 ignored", wr_ptr, 0);

      // R4 swing
      clr_udf = 1; @(negedge clk); clr_udf = 0;
      mode = 2;
      for (int i = 0; i < 4; i++) do_wr(DW'('h20 + i));
      chk("R4 filled", full, 1);
      begin
         int seq[7] = '{1, 2, 3, 2, 1, 0, 1};
         for (int k = 0; k < 7; k++) begin
            expect_code('h20 + seq[k]);
            do_hw();
            chk("R4 swing rd", rd_ptr, seq[k]);
         end
      end
      chk("R4 no udf", udf, 0);

      // R11 software reset
      do_wr('h30);
      do_wr('h31);
      chk("R5 ovf swing", ovf, 1);
      expect_code(0);
      sw_rst = 1; @(negedge clk); sw_rst = 0;
      chk("R11 rd", rd_ptr, 0);
      chk("R11 wr", wr_ptr, 0);
      chk("R11 ovf", ovf, 0);
      chk("R11 full", full, 0);
      @(negedge clk);
      chk("scoreboard drained R3", exp_q.size(), 0);
      done = 1;
      summary();
   end
endmodule